// File: doc/BRIEF.md
# Widening indexed multiply-accumulate engine

The block holds a small array of accumulator rows, each one vector wide, and updates them in place with unsigned four-way-widening products. A single start pulse hands it a full operation: how many quad-row groups to touch (one, two or four), the element mode, an element index, a 32-bit base select value with a small immediate offset, one first-source vector per group and one shared second-source vector. The engine captures all of these, then walks the selected rows one per clock, reading a row, adding the products to every lane and writing the row back.

Within a group of four consecutive rows, row i takes every fourth narrow element of its first source, starting at element i, so the four rows together consume the whole source vector. The second operand is a single narrow element chosen by the index, picked again inside every 128-bit segment of the second source. The first row of each group is derived from the base and offset reduced modulo a stride that shrinks as the group count grows; the groups sit one stride apart. A registered debug port reads any row.

Top module: `wmac_engine`

## Requirements
- R1: A synchronous active-high reset clears every accumulator row to zero and drives busy and done low.
- R2: In narrow mode (wide_mode = 0), row i (0..3) of a group adds to 32-bit lane j the product of first-source byte 4j+i and second-source byte 4·(j − j mod 4) + elem_idx, both zero-extended; elem_idx ranges over 0..15.
- R3: In wide mode (wide_mode = 1), row i adds to 64-bit lane e the product of first-source halfword 4e+i and second-source halfword 4·(e − e mod 2) + elem_idx[2:0]; elem_idx[3] has no effect.
- R4: With all-ones operands each lane gains exactly 0xFE01 (narrow) or 0xFFFE0001 (wide) per operation, with no carry into a neighbouring lane; lane sums wrap modulo the lane width.
- R5: grp_sel encodes the group count: 0 gives one group, 1 gives two, 2 or 3 give four. Group r uses src_a bits [r·VL +: VL]; src_b is shared by all groups.
- R6: With stride = (VL/8)/groups, the first row is ((base_sel + 4·off) mod stride) rounded down to a multiple of 4, where off is imm_off for one group and imm_off[0] otherwise; group r starts r·stride rows further on. The 32-bit sum wraps.
- R7: busy rises the cycle after an accepted start and stays high for exactly 4·groups cycles; done is a one-cycle pulse in the cycle busy drops.
- R8: A start pulse while busy is high is ignored: the running operation and its length are unaffected.
- R9: Rows outside the selected groups keep their values.
- R10: dbg_data presents the row addressed by dbg_row one clock after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation request, accepted when idle |
| grp_sel | input | 2 | Group count code |
| wide_mode | input | 1 | 0: bytes into 32-bit lanes, 1: halfwords into 64-bit lanes |
| elem_idx | input | 4 | Second-source element index |
| base_sel | input | 32 | Base row select value |
| imm_off | input | 2 | Immediate offset, scaled by 4 |
| src_a | input | 4·VL | First-source vectors, one per group |
| src_b | input | VL | Second-source vector |
| dbg_row | input | log2(VL/8) | Debug read row |
| dbg_data | output | VL | Debug read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |

## Verification
The bench builds the engine with VL = 256, giving 32 rows and strides of 32, 16 and 8 rows, so every group count lands on a distinct part of the array and the wrap of the start row within its stride is reachable. That width holds two 128-bit segments, which brings the per-segment reuse of the index into view in both modes: 32-bit lanes 4..7 and 64-bit lanes 2..3 must pick from the upper segment. Base values near 2^32 expose the wrap of the base-plus-offset sum.

// File: rtl/wmac_pkg.sv
package wmac_pkg;

  typedef enum logic {
    MODE_B32 = 1'b0,
    MODE_H64 = 1'b1
  } emode_t;

  typedef struct packed {
    logic [1:0]  grp;
    emode_t      mode;
    logic [3:0]  idx;
    logic [31:0] base;
    logic [1:0]  off;
  } op_t;

  // log2 of the group count
  function automatic logic [1:0] grp_log2(input logic [1:0] g);
    case (g)
      2'd0:    grp_log2 = 2'd0;
      2'd1:    grp_log2 = 2'd1;
      default: grp_log2 = 2'd2;
    endcase
  endfunction

  // index of the final row step of an operation (4 * groups - 1)
  function automatic logic [3:0] grp_last_step(input logic [1:0] g);
    case (g)
      2'd0:    grp_last_step = 4'd3;
      2'd1:    grp_last_step = 4'd7;
      default: grp_last_step = 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/wmac_rowgen.sv
module wmac_rowgen import wmac_pkg::*; #(
  parameter int ROWS = 32,
  localparam int RW = $clog2(ROWS)
) (
  input  logic [1:0]    grp,
  input  logic [31:0]   base,
  input  logic [1:0]    off,
  input  logic [3:0]    step,
  output logic [RW-1:0] row
);
  logic [1:0]    lg;
  logic [31:0]   off4;
  logic [31:0]   sum;
  logic [RW-1:0] mask;
  logic [RW-1:0] first;
  logic [RW-1:0] gofs;

  always_comb begin
    lg    = grp_log2(grp);
    off4  = (lg == 2'd0) ? {28'd0, off, 2'b00} : {28'd0, 1'b0, off[0], 2'b00};
    sum   = base + off4;                       // wraps at 2^32
    mask  = RW'((ROWS >> lg) - 1);             // stride - 1, stride a power of two
    first = sum[RW-1:0] & mask & ~RW'(3);
    gofs  = RW'(step[3:2]) << (RW - int'(lg)); // group * stride
    row   = first + gofs + RW'(step[1:0]);
  end
endmodule

// File: rtl/wmac_lanes.sv
module wmac_lanes import wmac_pkg::*; #(
  parameter int VL = 256
) (
  input  emode_t        mode,
  input  logic [3:0]    idx,
  input  logic [1:0]    rsel,
  input  logic [VL-1:0] a_vec,
  input  logic [VL-1:0] b_vec,
  input  logic [VL-1:0] acc_in,
  output logic [VL-1:0] acc_out
);
  localparam int N32 = VL / 32;
  localparam int N64 = VL / 64;
  localparam int K32 = 128 / 32;   // 32-bit lanes per segment
  localparam int K64 = 128 / 64;   // 64-bit lanes per segment

  logic [VL-1:0] res32;
  logic [VL-1:0] res64;

  for (genvar j = 0; j < N32; j++) begin : g_b32
    localparam int SEG = 4 * (j - (j % K32));
    logic [7:0]  a8, b8;
    logic [15:0] p16;
    always_comb begin
      a8  = a_vec[(4 * j + int'(rsel)) * 8 +: 8];
      b8  = b_vec[(SEG + int'(idx)) * 8 +: 8];
      p16 = {8'd0, a8} * {8'd0, b8};
      res32[j*32 +: 32] = acc_in[j*32 +: 32] + {16'd0, p16};
    end
  end

  for (genvar e = 0; e < N64; e++) begin : g_h64
    localparam int SEG = 4 * (e - (e % K64));
    logic [15:0] a16, b16;
    logic [31:0] p32;
    always_comb begin
      a16 = a_vec[(4 * e + int'(rsel)) * 16 +: 16];
      b16 = b_vec[(SEG + int'(idx[2:0])) * 16 +: 16];
      p32 = {16'd0, a16} * {16'd0, b16};
      res64[e*64 +: 64] = acc_in[e*64 +: 64] + {32'd0, p32};
    end
  end

  assign acc_out = (mode == MODE_H64) ? res64 : res32;
endmodule

// File: rtl/wmac_array.sv
module wmac_array #(
  parameter int VL   = 256,
  parameter int ROWS = 32,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] addr,
  input  logic [VL-1:0] wdata,
  output logic [VL-1:0] rdata,
  input  logic [RW-1:0] dbg_addr,
  output logic [VL-1:0] dbg_data
);
  logic [VL-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dbg_data <= '0;
    else     dbg_data <= mem[dbg_addr];
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/wmac_engine.sv
module wmac_engine import wmac_pkg::*; #(
  parameter int VL   = 256,
  localparam int ROWS = VL / 8,
  localparam int RW   = $clog2(ROWS),
  localparam int NG   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      grp_sel,
  input  logic            wide_mode,
  input  logic [3:0]      elem_idx,
  input  logic [31:0]     base_sel,
  input  logic [1:0]      imm_off,
  input  logic [NG*VL-1:0] src_a,
  input  logic [VL-1:0]   src_b,
  input  logic [RW-1:0]   dbg_row,
  output logic [VL-1:0]   dbg_data,
  output logic            busy,
  output logic            done
);
  op_t              op_q;
  logic [NG*VL-1:0] a_q;
  logic [VL-1:0]    b_q;
  logic [3:0]       step_q;
  logic [RW-1:0]    row;
  logic [VL-1:0]    a_vec, acc_rd, acc_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      step_q <= '0;
      op_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy   <= 1'b1;
        step_q <= '0;
        op_q   <= '{grp: grp_sel, mode: emode_t'(wide_mode), idx: elem_idx,
                    base: base_sel, off: imm_off};
        a_q    <= src_a;
        b_q    <= src_b;
      end else if (busy) begin
        if (step_q == grp_last_step(op_q.grp)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        step_q <= step_q + 4'd1;
      end
    end
  end

  assign a_vec = a_q[int'(step_q[3:2]) * VL +: VL];

  wmac_rowgen #(.ROWS(ROWS)) u_rowgen (
    .grp  (op_q.grp),
    .base (op_q.base),
    .off  (op_q.off),
    .step (step_q),
    .row  (row)
  );

  wmac_lanes #(.VL(VL)) u_lanes (
    .mode    (op_q.mode),
    .idx     (op_q.idx),
    .rsel    (step_q[1:0]),
    .a_vec   (a_vec),
    .b_vec   (b_q),
    .acc_in  (acc_rd),
    .acc_out (acc_wr)
  );

  wmac_array #(.VL(VL), .ROWS(ROWS)) u_array (
    .clk      (clk),
    .rst      (rst),
    .we       (busy),
    .addr     (row),
    .wdata    (acc_wr),
    .rdata    (acc_rd),
    .dbg_addr (dbg_row),
    .dbg_data (dbg_data)
  );
endmodule

// File: rtl/wmac_chk.sv
module wmac_chk import wmac_pkg::*; (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [1:0] grp_sel,
  input logic       busy,
  input logic       done
);
  logic [4:0] cnt;
  logic [4:0] expn;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      expn <= '0;
    end else if (start && !busy) begin
      cnt  <= '0;
      expn <= {1'b0, grp_last_step(grp_sel)} + 5'd1;
    end else if (busy) begin
      cnt <= cnt + 5'd1;
    end
  end

  // R1: reset leaves the engine idle
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!busy && !done));

  // R7: busy follows an accepted start
  p_accept_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: busy only drops together with done
  p_busy_drop_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R7, R8: operation length set by the accepted start only
  p_run_length_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt == expn));
endmodule

bind wmac_engine wmac_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .grp_sel (grp_sel),
  .busy    (busy),
  .done    (done)
);

// File: tb/sim_wmac_engine.sv
module sim_wmac_engine;
  localparam int VL   = 256;
  localparam int ROWS = VL / 8;
  localparam int RW   = $clog2(ROWS);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst = 1'b1, start = 1'b0, wide_mode = 1'b0;
  logic [1:0]      grp_sel = '0, imm_off = '0;
  logic [3:0]      elem_idx = '0;
  logic [31:0]     base_sel = '0;
  logic [4*VL-1:0] src_a = '0;
  logic [VL-1:0]   src_b = '0;
  logic [RW-1:0]   dbg_row = '0;
  logic [VL-1:0]   dbg_data;
  logic            busy, done;

  wmac_engine #(.VL(VL)) u0 (
    .clk(clk), .rst(rst), .start(start), .grp_sel(grp_sel), .wide_mode(wide_mode),
    .elem_idx(elem_idx), .base_sel(base_sel), .imm_off(imm_off), .src_a(src_a),
    .src_b(src_b), .dbg_row(dbg_row), .dbg_data(dbg_data), .busy(busy), .done(done)
  );

  logic [VL-1:0] model [ROWS];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [VL-1:0] exp_q [$];
  string         tag_q [$];
  logic          rd_v = 1'b0, rd_v_d = 1'b0;

  task automatic check(bit ok, string tag, logic [VL-1:0] act, logic [VL-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one debug read result per flagged cycle (R10)
  always @(posedge clk) rd_v_d <= rd_v;
  always @(negedge clk) begin
    if (rd_v_d && exp_q.size() > 0) begin
      logic [VL-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(dbg_data === e, t, dbg_data, e);
    end
  end

  task automatic read_all(string tag);
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      dbg_row = RW'(r);
      exp_q.push_back(model[r]);
      tag_q.push_back($sformatf("%s R9 R10 row %0d", tag, r));
      rd_v = 1'b1;
    end
    @(negedge clk);
    rd_v = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic model_op(int gs, bit md, int ix, logic [31:0] bs, int of,
                          logic [4*VL-1:0] a, logic [VL-1:0] b);
    int n, stride, offv, s, row;
    logic [31:0] sum;
    n      = (gs == 0) ? 1 : (gs == 1) ? 2 : 4;
    stride = ROWS / n;
    offv   = (n == 1) ? of * 4 : (of % 2) * 4;
    sum    = bs + 32'(offv);
    s      = int'(sum % 32'(stride));
    s      = s - (s % 4);
    for (int g = 0; g < n; g++) begin
      for (int i = 0; i < 4; i++) begin
        row = s + g * stride + i;
        if (!md) begin
          for (int e = 0; e < VL / 32; e++) begin
            logic [31:0] acc, a8, b8;
            a8  = 32'(a[g*VL + (4*e + i)*8 +: 8]);
            b8  = 32'(b[(4*(e - e % 4) + ix)*8 +: 8]);
            acc = model[row][e*32 +: 32];
            model[row][e*32 +: 32] = acc + a8 * b8;
          end
        end else begin
          for (int e = 0; e < VL / 64; e++) begin
            logic [63:0] acc, a16, b16;
            a16 = 64'(a[g*VL + (4*e + i)*16 +: 16]);
            b16 = 64'(b[(4*(e - e % 2) + (ix % 8))*16 +: 16]);
            acc = model[row][e*64 +: 64];
            model[row][e*64 +: 64] = acc + a16 * b16;
          end
        end
      end
    end
  endtask

  // driver: updates the reference, launches the operation, checks its timing
  task automatic run_op(int gs, bit md, int ix, logic [31:0] bs, int of,
                        logic [4*VL-1:0] a, logic [VL-1:0] b, string tag, bit poke);
    int cnt, n;
    n = (gs == 0) ? 1 : (gs == 1) ? 2 : 4;
    model_op(gs, md, ix, bs, of, a, b);
    @(negedge clk);
    start = 1'b1; grp_sel = 2'(gs); wide_mode = md; elem_idx = 4'(ix);
    base_sel = bs; imm_off = 2'(of); src_a = a; src_b = b;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, {tag, " R7 busy after start"}, VL'(busy), VL'(1));
    cnt = 0;
    while (busy === 1'b1 && cnt < 40) begin
      cnt++;
      if (poke && cnt == 2) begin
        // R8: a competing request while busy
        start = 1'b1; grp_sel = 2'd0; wide_mode = ~md; elem_idx = 4'd5;
        base_sel = 32'd20; imm_off = 2'd1; src_a = ~a; src_b = ~b;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(cnt == 4 * n, {tag, " R7 R8 busy length"}, VL'(cnt), VL'(4 * n));
    check(done === 1'b1, {tag, " R7 done pulse"}, VL'(done), VL'(1));
    @(negedge clk);
    check(done === 1'b0, {tag, " R7 done one cycle"}, VL'(done), VL'(0));
  endtask

  task automatic rnd_ops(output logic [4*VL-1:0] a, output logic [VL-1:0] b);
    for (int w = 0; w < 4 * VL / 32; w++) a[w*32 +: 32] = $urandom;
    for (int w = 0; w < VL / 32; w++)     b[w*32 +: 32] = $urandom;
  endtask

  initial begin
    logic [4*VL-1:0] a;
    logic [VL-1:0]   b;
    for (int r = 0; r < ROWS; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(busy === 1'b0 && done === 1'b0, "R1 idle after reset", VL'({busy, done}), VL'(0));
    read_all("R1 reset");

    // narrow mode, every index, varied base and offset
    for (int ix = 0; ix < 16; ix++) begin
      rnd_ops(a, b);
      run_op(0, 1'b0, ix, 32'(ix * 7), ix % 4, a, b, $sformatf("R2 R6 idx %0d", ix), 1'b0);
      read_all($sformatf("R2 idx %0d", ix));
    end

    // wide mode, every index, upper index bit aliased
    for (int ix = 0; ix < 16; ix++) begin
      rnd_ops(a, b);
      run_op(0, 1'b1, ix, 32'(ix * 5 + 3), (ix + 1) % 4, a, b, $sformatf("R3 idx %0d", ix), 1'b0);
      read_all($sformatf("R3 idx %0d", ix));
    end

    // group counts, both modes, grp_sel 3 aliases four groups
    for (int gs = 1; gs < 4; gs++) begin
      for (int md = 0; md < 2; md++) begin
        rnd_ops(a, b);
        run_op(gs, md[0], 9 + gs, 32'(gs * 11 + md), 3, a, b, $sformatf("R5 grp %0d mode %0d", gs, md), 1'b0);
        read_all($sformatf("R5 grp %0d mode %0d", gs, md));
      end
    end

    // base wrap at 2^32 and within the stride
    rnd_ops(a, b);
    run_op(0, 1'b0, 2, 32'hFFFF_FFFD, 3, a, b, "R6 wrap one group", 1'b0);
    read_all("R6 wrap one group");
    rnd_ops(a, b);
    run_op(2, 1'b1, 6, 32'hFFFF_FFFF, 1, a, b, "R6 wrap four groups", 1'b0);
    read_all("R6 wrap four groups");
    rnd_ops(a, b);
    run_op(1, 1'b0, 15, 32'd14, 1, a, b, "R6 wrap two groups", 1'b0);
    read_all("R6 wrap two groups");

    // all-ones operands
    a = '1; b = '1;
    run_op(2, 1'b0, 15, 32'd0, 0, a, b, "R4 max narrow", 1'b0);
    run_op(2, 1'b0, 0, 32'd0, 0, a, b, "R4 max narrow again", 1'b0);
    read_all("R4 max narrow");
    run_op(2, 1'b1, 7, 32'd4, 0, a, b, "R4 max wide", 1'b0);
    read_all("R4 max wide");

    // start while busy ignored
    rnd_ops(a, b);
    run_op(1, 1'b0, 3, 32'd6, 0, a, b, "R8 start while busy", 1'b1);
    read_all("R8 start while busy");

    // reset clears everything again
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < ROWS; r++) model[r] = '0;
    check(busy === 1'b0 && done === 1'b0, "R1 idle after second reset", VL'({busy, done}), VL'(0));
    read_all("R1 second reset");

    check(exp_q.size() == 0, "R10 all reads consumed", VL'(exp_q.size()), VL'(0));
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule